// File: doc/BRIEF.md
# Basic Interval Timer with Watchdog

The block derives a slow tick from the system clock through a prescaler whose division ratio is a power of two chosen by software. Each tick advances an 8-bit interval counter. When that counter wraps from its all-ones value back to zero, the block emits a one-cycle interrupt pulse. The same tick also drives an 8-bit watchdog counter. Once the watchdog counter reaches its all-ones value, the block pulls down an active-low reset request line for the rest of the chip.

Software reaches the block through a small register port with two addresses. Address 0 is a control word. It holds the divider select, the watchdog enable and the live watchdog count. Writing the count field reloads the watchdog, and writing zero there is how software services it. Address 1 is a read-only view of the interval counter.

The divider is 2^(BASE_LOG2 − sel). With the default BASE_LOG2 of 13, the ratio runs from 8192 clocks per tick (sel = 0) down to 1024 clocks per tick (sel = 3).

Top module: `bt_wdt_top`

## Requirements
- R1: A write with `addr`=0 loads control bits [3:2] as the divider select, bits [15:8] as the watchdog count and bit 16 as the watchdog enable, all in the same cycle. A read at `addr`=0 returns these three fields in the same positions, with zeros in every other bit.
- R2: One prescaled tick occurs every 2^(BASE_LOG2 − sel) clock cycles. The first tick after reset comes at the end of the first full period.
- R3: A control write that changes the divider select restarts the prescaler from zero in the following cycle. A control write that keeps the same select leaves the prescaler running.
- R4: The interval counter starts at 0 and increments by one on every tick. On a tick at 0xFF it wraps to 0. A read at `addr`=1 returns the counter in bits [7:0], with zeros above.
- R5: `irq_pulse` is high for exactly the one cycle after the clock edge at which the counter wraps from 0xFF to 0. It is low at every other time.
- R6: While enabled, the watchdog count increments by one on each tick and stays at 0xFF once it gets there. While disabled, it holds its value. A control write overrides any increment in that cycle.
- R7: When the watchdog is enabled and its count is 0xFF, `wdt_rst_n` goes low from the next clock edge.
- R8: Once low, `wdt_rst_n` stays low until `rst_n` is asserted, whatever is written.
- R9: A write with `addr`=1 changes no state of the block.
- R10: After reset, the control word reads 0, the interval counter reads 0, `irq_pulse` is low and `wdt_rst_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | Register select: 0 control, 1 interval counter |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for `addr` |
| irq_pulse | output | 1 | One-cycle interrupt on counter wrap |
| wdt_rst_n | output | 1 | Active-low watchdog reset request |

## Verification
The assertions assume `rst_n` is applied before any checked activity. They also assume BASE_LOG2 is at least one more than the largest select value, so that every tick period is two or more cycles. Under that assumption a tick or a wrap never lands in two consecutive cycles. The bench drives all inputs between clock edges and keeps BASE_LOG2 at 5 so that many wraps fit in a short run. Its random control writes pick watchdog values weighted towards 0xFF. It applies `rst_n` after each trip so that the stimulus reaches untripped states again.

// File: rtl/bt_pkg.sv
package bt_pkg;
    localparam int SEL_W   = 2;
    localparam int SEL_LSB = 2;
    localparam int WD_LSB  = 8;
    localparam int EN_BIT  = 16;
    localparam int DATA_W  = 32;
    localparam int CNT_W   = 8;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             en;
    } ctrl_t;
endpackage

// File: rtl/bt_prescaler.sv
module bt_prescaler #(
    parameter int BASE_LOG2 = 13,
    parameter int SEL_W     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    input  logic             restart,
    output logic             tick
);
    localparam int PW = BASE_LOG2;

    typedef struct packed {
        logic [PW-1:0] pre;
    } pre_st_t;

    pre_st_t       st_d, st_q;
    logic [PW:0]   div_w;
    logic [PW:0]   term_w;

    always_comb begin
        div_w  = {{PW{1'b0}}, 1'b1} << (PW - int'(sel));
        term_w = div_w - 1'b1;
        tick   = (st_q.pre == term_w[PW-1:0]);
        st_d   = st_q;
        if (restart || tick) st_d.pre = '0;
        else                 st_d.pre = st_q.pre + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: a tick period is at least two cycles
    a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/bt_interval.sv
module bt_interval #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    output logic [CNT_W-1:0] count,
    output logic             irq
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             irq;
    } iv_st_t;

    iv_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (tick) begin
            if (&st_q.cnt) begin
                st_d.cnt = '0;
                st_d.irq = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.cnt;
    assign irq   = st_q.irq;

    a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (&count)) |=> (count == '0));
    a_r5_irq_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (&count)) |=> irq);
    a_r5_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(count));
endmodule

// File: rtl/bt_watchdog.sv
module bt_watchdog #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             en,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             rst_req_n
);
    typedef struct packed {
        logic [CNT_W-1:0] wd;
        logic             trip;
    } wd_st_t;

    wd_st_t st_d, st_q;
    logic   full;

    always_comb begin
        full      = &st_q.wd;
        st_d      = st_q;
        st_d.trip = st_q.trip | (en & full);
        if (load)                     st_d.wd = load_val;
        else if (tick && en && !full) st_d.wd = st_q.wd + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count     = st_q.wd;
    assign rst_req_n = ~st_q.trip;

    a_r7_trip: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (&count)) |=> !rst_req_n);
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_req_n |=> !rst_req_n);
    a_r6_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !load) |=> $stable(count));
endmodule

// File: rtl/bt_wdt_top.sv
module bt_wdt_top
    import bt_pkg::*;
#(
    parameter int BASE_LOG2 = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_pulse,
    output logic              wdt_rst_n
);
    ctrl_t            ctrl_d, ctrl_q;
    logic             ctrl_wr;
    logic [SEL_W-1:0] wr_sel;
    logic             restart;
    logic             tick;
    logic [CNT_W-1:0] iv_count;
    logic [CNT_W-1:0] wd_count;

    always_comb begin
        ctrl_wr = wr_en && !addr;
        wr_sel  = wr_data[SEL_LSB +: SEL_W];
        restart = ctrl_wr && (wr_sel != ctrl_q.sel);
        ctrl_d  = ctrl_q;
        if (ctrl_wr) begin
            ctrl_d.sel = wr_sel;
            ctrl_d.en  = wr_data[EN_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    bt_prescaler #(.BASE_LOG2(BASE_LOG2), .SEL_W(SEL_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .sel(ctrl_q.sel), .restart(restart), .tick(tick));

    bt_interval #(.CNT_W(CNT_W)) u_iv (
        .clk(clk), .rst_n(rst_n), .tick(tick), .count(iv_count), .irq(irq_pulse));

    bt_watchdog #(.CNT_W(CNT_W)) u_wd (
        .clk(clk), .rst_n(rst_n), .tick(tick), .en(ctrl_q.en), .load(ctrl_wr),
        .load_val(wr_data[WD_LSB +: CNT_W]), .count(wd_count), .rst_req_n(wdt_rst_n));

    always_comb begin
        rd_data = '0;
        if (!addr) begin
            rd_data[SEL_LSB +: SEL_W] = ctrl_q.sel;
            rd_data[WD_LSB +: CNT_W]  = wd_count;
            rd_data[EN_BIT]           = ctrl_q.en;
        end else begin
            rd_data[CNT_W-1:0] = iv_count;
        end
    end

    a_r3_restart: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !tick);
    a_r9_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr) |=> $stable(ctrl_q));
endmodule

// File: tb/sim_bt_wdt_top.sv
module sim_bt_wdt_top;
    localparam int BL = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        addr = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq_pulse;
    logic        wdt_rst_n;

    int errors = 0;
    int checks = 0;

    int       m_pre, m_cnt, m_wd, m_sel;
    bit       m_en, m_trip, m_irq;

    bt_wdt_top #(.BASE_LOG2(BL)) u0 (.*);

    always #2 clk = ~clk;

    function automatic int div_of(int sel);
        return 1 << (BL - sel);
    endfunction

    function automatic logic [31:0] exp_rd(bit a);
        if (!a) return (32'(m_en) << 16) | (32'(m_wd) << 8) | (32'(m_sel) << 2);
        return 32'(m_cnt);
    endfunction

    // reference model, updated at each rising edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pre = 0; m_cnt = 0; m_wd = 0; m_sel = 0;
            m_en = 0; m_trip = 0; m_irq = 0;
        end else begin
            bit tk, wr;
            int nsel;
            tk = (m_pre == div_of(m_sel) - 1);
            wr = wr_en && !addr;
            nsel = int'(wr_data[3:2]);
            m_trip = m_trip || (m_en && m_wd == 255);
            m_irq = tk && m_cnt == 255;
            if (wr && nsel != m_sel) m_pre = 0;
            else if (tk)             m_pre = 0;
            else                     m_pre = m_pre + 1;
            if (tk) m_cnt = (m_cnt == 255) ? 0 : m_cnt + 1;
            if (wr)                           m_wd = int'(wr_data[15:8]);
            else if (tk && m_en && m_wd != 255) m_wd = m_wd + 1;
            if (wr) begin
                m_sel = nsel;
                m_en  = wr_data[16];
            end
        end
    end

    task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    // compare all outputs at the falling edge
    task automatic compare_all();
        logic [31:0] e;
        e = exp_rd(addr);
        if (!addr) check(rd_data === e, "R1 R6 control readback", rd_data, e);
        else       check(rd_data === e, "R2 R3 R4 counter readback", rd_data, e);
        check(irq_pulse === m_irq, "R5 irq pulse", 32'(irq_pulse), 32'(m_irq));
        check(wdt_rst_n === !m_trip, "R7 R8 reset request", 32'(wdt_rst_n), 32'(!m_trip));
    endtask

    task automatic step(input bit we, input bit a, input logic [31:0] d);
        @(negedge clk);
        compare_all();
        wr_en = we; addr = a; wr_data = d;
    endtask

    task automatic idle(input int n, input bit a);
        for (int i = 0; i < n; i++) step(1'b0, a, '0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0;
        @(negedge clk);
        // R10 reset state
        addr = 1'b0; #0.1;
        check(rd_data === 32'h0, "R10 control after reset", rd_data, 32'h0);
        addr = 1'b1; #0.1;
        check(rd_data === 32'h0, "R10 counter after reset", rd_data, 32'h0);
        check(irq_pulse === 1'b0, "R10 irq after reset", 32'(irq_pulse), 32'h0);
        check(wdt_rst_n === 1'b1, "R10 rst_req after reset", 32'(wdt_rst_n), 32'h1);
        rst_n = 1'b1;
    endtask

    function automatic logic [31:0] ctl(int sel, bit en, int wd);
        return (32'(en) << 16) | (32'(wd & 255) << 8) | (32'(sel & 3) << 2);
    endfunction

    initial begin : watchdog_timer
        repeat (190000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog timeout");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed));
        do_reset();
        // R2 R4 R5: several wraps at the fastest divider, counter view
        idle(10, 1'b1);
        step(1'b1, 1'b0, ctl(3, 0, 0));
        idle(2100, 1'b1);
        // R3: rewrite the same select, then change it
        step(1'b1, 1'b0, ctl(3, 0, 0));
        idle(7, 1'b1);
        step(1'b1, 1'b0, ctl(1, 0, 0));
        idle(300, 1'b1);
        // R9: writes at addr 1 are ignored
        for (int i = 0; i < 20; i++) step(1'b1, 1'b1, $urandom());
        idle(3, 1'b0);
        // R6 R7 R8: watchdog runs up and trips, then writes cannot clear it
        step(1'b1, 1'b0, ctl(3, 1, 250));
        idle(60, 1'b0);
        step(1'b1, 1'b0, ctl(3, 1, 0));
        idle(10, 1'b0);
        step(1'b1, 1'b0, ctl(3, 0, 0));
        idle(10, 1'b0);
        do_reset();
        // R6: disabled watchdog holds at 0xFF without tripping
        step(1'b1, 1'b0, ctl(2, 0, 255));
        idle(40, 1'b0);
        // random mix
        for (int blk = 0; blk < 6; blk++) begin
            for (int i = 0; i < 12000; i++) begin
                int r;
                r = int'($urandom_range(0, 99));
                if (r < 2) begin
                    int wd;
                    wd = ($urandom_range(0, 3) == 0) ? int'($urandom_range(240, 255))
                                                     : int'($urandom_range(0, 255));
                    step(1'b1, 1'b0, ctl(int'($urandom_range(0, 3)), bit'($urandom_range(0, 1)), wd)
                                     | ($urandom() & 32'hfffe_00f3));
                end else if (r < 4) begin
                    step(1'b1, 1'b1, $urandom());
                end else begin
                    step(1'b0, bit'($urandom_range(0, 1)), $urandom());
                end
            end
            do_reset();
        end
        idle(2, 1'b0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule